// File: doc/BRIEF.md
# Variable Block Size SAD Engine

This block is the arithmetic core of a full-search motion estimator that uses variable block sizes. On each clock it takes one candidate position: the 16×16 pixels of the current macroblock and the 16×16 reference pixels at that candidate. It returns every sum of absolute differences that a partition search needs, 41 values in all. The surrounding search controller steps through every position in the search window and presents one candidate per cycle. A downstream comparator picks the best match for each partition from the parallel SAD outputs.

Inside, each pixel pair yields an absolute difference. Each 4×4 sub-block reduces its 16 differences with a carry-save tree that ends in a single carry-propagate add. All larger partitions are then built by adding 4×4 results, never from pixels again. The pipeline is five registers deep, and a valid bit travels with the data.

Top module: `vbs_sad_engine`

## Requirements
- R1: Pixel (row r, column c) of the macroblock, with r and c counted 0..15 from the top-left, occupies bits [8*(16*r+c) +: 8] of `cur_pix` and `ref_pix`, unsigned. Its absolute difference |cur − ref| counts toward every partition that contains it.
- R2: `sad_4x4` holds 16 fields of 12 bits. Field k = 4*by + bx covers pixel rows 4*by..4*by+3 and columns 4*bx..4*bx+3. The largest value, 4080, is reported without wrap.
- R3: `sad_8x4` (8 wide, 4 tall) holds 8 fields of 13 bits, with field j covering columns 8*(j%2).. and rows 4*(j/2)... `sad_4x8` (4 wide, 8 tall) holds 8 fields of 13 bits, with field j covering columns 4*(j%4).. and rows 8*(j/4)...
- R4: `sad_8x8` holds 4 fields of 14 bits, with field q covering columns 8*(q%2).. and rows 8*(q/2)...
- R5: `sad_16x8` holds 2 fields of 15 bits, with field i covering rows 8*i..8*i+7. `sad_8x16` holds 2 fields of 15 bits, with field i covering columns 8*i..8*i+7.
- R6: `sad_16x16` is the 16-bit SAD of the whole macroblock, and its largest value, 65280, is reported without wrap.
- R7: `out_valid` rises exactly 5 clock cycles after a beat is accepted with `in_valid` high. In that cycle all 41 SADs belong to that beat.
- R8: A new beat is accepted on every clock. Back-to-back beats come out on consecutive cycles, each with its own results.
- R9: While `rst_n` is low and for the following 5 cycles, `out_valid` is low, even if `in_valid` was high during reset. Beats in flight when reset is applied are dropped.
- R10: A cycle with `in_valid` low produces no `out_valid` 5 cycles later, whatever its pixel data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Candidate pixels on this cycle are to be processed |
| cur_pix | input | 2048 | Current macroblock, 256 pixels of 8 bits in raster order |
| ref_pix | input | 2048 | Reference pixels at the candidate, same layout |
| out_valid | output | 1 | All SAD outputs belong to a beat accepted 5 cycles earlier |
| sad_4x4 | output | 192 | 16 SADs of 4×4 sub-blocks, 12 bits each |
| sad_8x4 | output | 104 | 8 SADs of 8-wide 4-tall partitions, 13 bits each |
| sad_4x8 | output | 104 | 8 SADs of 4-wide 8-tall partitions, 13 bits each |
| sad_8x8 | output | 56 | 4 SADs of 8×8 partitions, 14 bits each |
| sad_16x8 | output | 30 | 2 SADs of 16-wide 8-tall partitions, 15 bits each |
| sad_8x16 | output | 30 | 2 SADs of 8-wide 16-tall partitions, 15 bits each |
| sad_16x16 | output | 16 | SAD of the full macroblock |

## Verification
On every cycle the assertions check four things. The 5-cycle valid latency holds, and the outputs stay quiet after reset. Each larger partition equals the sum of the smaller outputs it is made of: pairs, quads, halves and the whole macroblock. No 4×4 result exceeds its maximum. These checks cannot show that the absolute differences are right or that each field is taken from the right pixels. Only the bench scenarios compare every field with values computed from pixels. Those scenarios cover random data, a distinct pattern per sub-block, a single differing pixel, full-scale differences of both signs, idle gaps and a reset applied mid-stream.

// File: rtl/vbs_sad_pkg.sv
// Package: shared width helpers for the variable block size SAD engine.
// Assumes unsigned pixels; a sum of n pixels needs pix_w + clog2(n) bits.
package vbs_sad_pkg;

    // Width of a SAD accumulated over npix absolute differences
    function automatic int sad_w(input int pix_w, input int npix);
        return pix_w + $clog2(npix);
    endfunction

    // Pipeline depth from pixel input to SAD output
    localparam int SAD_LATENCY = 5;

endpackage

// File: rtl/vbs_absdiff_array.sv
// Module: per-pixel absolute difference, one register stage.
// Takes the difference with a borrow bit; when the borrow is set the result
// is inverted and incremented. Assumes unsigned pixels of PIX_W bits.
module vbs_absdiff_array #(
    parameter int PIX_W = 8,
    parameter int NPIX  = 256
) (
    input  logic                    clk,
    input  logic [NPIX*PIX_W-1:0]   cur_pix,
    input  logic [NPIX*PIX_W-1:0]   ref_pix,
    output logic [NPIX*PIX_W-1:0]   ad_q
);

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        logic [PIX_W:0]   diff;
        logic [PIX_W-1:0] mag;
        logic [PIX_W-1:0] ad_r;

        assign diff = {1'b0, cur_pix[p*PIX_W +: PIX_W]} - {1'b0, ref_pix[p*PIX_W +: PIX_W]};

        // Pick the magnitude by the borrow (sign) of the subtraction
        always_comb begin
            if (diff[PIX_W]) mag = ~diff[PIX_W-1:0] + 1'b1;
            else             mag = diff[PIX_W-1:0];
        end

        // Register the magnitude (stage 1)
        always_ff @(posedge clk) begin
            ad_r <= mag;
        end

        assign ad_q[p*PIX_W +: PIX_W] = ad_r;
    end

endmodule

// File: rtl/vbs_blk_sad.sv
// Module: SAD of one square sub-block.
// A carry-save tree of 3:2 compressors reduces BLK_DIM*BLK_DIM absolute
// differences to a sum/carry pair, which is registered (stage 2). A single
// carry-propagate add forms the SAD (stage 3). The arithmetic is modulo
// 2^W; W is wide enough for the full sum, so no result wraps.
module vbs_blk_sad import vbs_sad_pkg::*; #(
    parameter int PIX_W   = 8,
    parameter int BLK_DIM = 4
) (
    input  logic                                   clk,
    input  logic [BLK_DIM*BLK_DIM*PIX_W-1:0]       ad_blk,
    output logic [sad_w(PIX_W, BLK_DIM*BLK_DIM)-1:0] sad_q
);

    localparam int BPIX = BLK_DIM * BLK_DIM;
    localparam int W    = sad_w(PIX_W, BPIX);
    localparam int NGRP = BPIX / 3;

    logic [W-1:0] lv [BPIX];
    logic [W-1:0] nv [BPIX];
    int           n_cur;
    int           n_nxt;
    logic [W-1:0] csa_s;
    logic [W-1:0] csa_c;
    logic [W-1:0] s_q;
    logic [W-1:0] c_q;

    // Reduce the operand list level by level with 3:2 compressors until two remain
    always_comb begin
        for (int i = 0; i < BPIX; i++) begin
            lv[i] = W'(ad_blk[i*PIX_W +: PIX_W]);
            nv[i] = '0;
        end
        n_cur = BPIX;
        n_nxt = 0;
        for (int lvl = 0; lvl < BPIX; lvl++) begin
            if (n_cur > 2) begin
                for (int i = 0; i < BPIX; i++) nv[i] = '0;
                n_nxt = 0;
                for (int g = 0; g < NGRP; g++) begin
                    if (3*g + 2 < n_cur) begin
                        nv[n_nxt]   = lv[3*g] ^ lv[3*g+1] ^ lv[3*g+2];
                        nv[n_nxt+1] = ((lv[3*g] & lv[3*g+1]) |
                                       (lv[3*g] & lv[3*g+2]) |
                                       (lv[3*g+1] & lv[3*g+2])) << 1;
                        n_nxt = n_nxt + 2;
                    end
                end
                for (int r = 0; r < BPIX; r++) begin
                    if (r >= 3*(n_cur/3) && r < n_cur) begin
                        nv[n_nxt] = lv[r];
                        n_nxt = n_nxt + 1;
                    end
                end
                for (int i = 0; i < BPIX; i++) lv[i] = nv[i];
                n_cur = n_nxt;
            end
        end
        csa_s = lv[0];
        csa_c = lv[1];
    end

    // Hold the redundant sum/carry pair (stage 2)
    always_ff @(posedge clk) begin
        s_q <= csa_s;
        c_q <= csa_c;
    end

    // Resolve the pair with one carry-propagate adder (stage 3)
    always_ff @(posedge clk) begin
        sad_q <= s_q + c_q;
    end

endmodule

// File: rtl/vbs_part_merge.sv
// Module: builds all larger partition SADs from the 4x4 SADs.
// Stage 4 forms the pairs (8x4, 4x8) and quads (8x8); stage 5 forms the
// halves (16x8, 8x16) and the whole block. Earlier results are delayed so
// all groups leave together. Assumes a macroblock of 4x4 sub-blocks
// (MB_DIM == 4*BLK_DIM), with sub-blocks numbered in raster order.
module vbs_part_merge import vbs_sad_pkg::*; #(
    parameter int PIX_W   = 8,
    parameter int MB_DIM  = 16,
    parameter int BLK_DIM = 4,
    localparam int NB     = MB_DIM / BLK_DIM,
    localparam int HB     = NB / 2,
    localparam int BPIX   = BLK_DIM * BLK_DIM,
    localparam int NPIX   = MB_DIM * MB_DIM,
    localparam int W4     = sad_w(PIX_W, BPIX),
    localparam int W84    = sad_w(PIX_W, 2*BPIX),
    localparam int W88    = sad_w(PIX_W, NPIX/4),
    localparam int WH     = sad_w(PIX_W, NPIX/2),
    localparam int WT     = sad_w(PIX_W, NPIX)
) (
    input  logic                    clk,
    input  logic [NB*NB*W4-1:0]     s4_in,
    output logic [NB*NB*W4-1:0]     sad_4x4,
    output logic [NB*HB*W84-1:0]    sad_8x4,
    output logic [NB*HB*W84-1:0]    sad_4x8,
    output logic [HB*HB*W88-1:0]    sad_8x8,
    output logic [HB*WH-1:0]        sad_16x8,
    output logic [HB*WH-1:0]        sad_8x16,
    output logic [WT-1:0]           sad_16x16
);

    logic [NB*NB*W4-1:0]  s4_a;
    logic [NB*HB*W84-1:0] s84_a;
    logic [NB*HB*W84-1:0] s48_a;
    logic [HB*HB*W88-1:0] s88_a;

    // Stage 4: horizontal pairs, vertical pairs and quads of 4x4 results
    always_ff @(posedge clk) begin
        s4_a <= s4_in;
        for (int j = 0; j < NB*HB; j++) begin
            s84_a[j*W84 +: W84] <=
                W84'(s4_in[((j/HB)*NB + 2*(j%HB))*W4 +: W4]) +
                W84'(s4_in[((j/HB)*NB + 2*(j%HB) + 1)*W4 +: W4]);
            s48_a[j*W84 +: W84] <=
                W84'(s4_in[((2*(j/NB))*NB + (j%NB))*W4 +: W4]) +
                W84'(s4_in[((2*(j/NB)+1)*NB + (j%NB))*W4 +: W4]);
        end
        for (int q = 0; q < HB*HB; q++) begin
            s88_a[q*W88 +: W88] <=
                W88'(s4_in[((2*(q/HB))*NB + 2*(q%HB))*W4 +: W4]) +
                W88'(s4_in[((2*(q/HB))*NB + 2*(q%HB) + 1)*W4 +: W4]) +
                W88'(s4_in[((2*(q/HB)+1)*NB + 2*(q%HB))*W4 +: W4]) +
                W88'(s4_in[((2*(q/HB)+1)*NB + 2*(q%HB) + 1)*W4 +: W4]);
        end
    end

    // Stage 5: halves and whole block from quads; delay the rest to align
    always_ff @(posedge clk) begin
        sad_4x4 <= s4_a;
        sad_8x4 <= s84_a;
        sad_4x8 <= s48_a;
        sad_8x8 <= s88_a;
        for (int i = 0; i < HB; i++) begin
            sad_16x8[i*WH +: WH] <= WH'(s88_a[(2*i)*W88 +: W88]) +
                                    WH'(s88_a[(2*i+1)*W88 +: W88]);
            sad_8x16[i*WH +: WH] <= WH'(s88_a[i*W88 +: W88]) +
                                    WH'(s88_a[(i+2)*W88 +: W88]);
        end
        sad_16x16 <= WT'(s88_a[0 +: W88]) + WT'(s88_a[W88 +: W88]) +
                     WT'(s88_a[2*W88 +: W88]) + WT'(s88_a[3*W88 +: W88]);
    end

endmodule

// File: rtl/vbs_sad_engine.sv
// Module: variable block size SAD engine, top level.
// Accepts one candidate position per clock and returns all 41 partition
// SADs 5 cycles later with out_valid. Only the valid pipeline is reset
// (synchronous, active low); data registers run free. Assumes
// MB_DIM == 4*BLK_DIM.
module vbs_sad_engine import vbs_sad_pkg::*; #(
    parameter int PIX_W   = 8,
    parameter int MB_DIM  = 16,
    parameter int BLK_DIM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic [MB_DIM*MB_DIM*PIX_W-1:0] cur_pix,
    input  logic [MB_DIM*MB_DIM*PIX_W-1:0] ref_pix,
    output logic out_valid,
    output logic [(MB_DIM/BLK_DIM)*(MB_DIM/BLK_DIM)*sad_w(PIX_W, BLK_DIM*BLK_DIM)-1:0]   sad_4x4,
    output logic [(MB_DIM/BLK_DIM)*(MB_DIM/BLK_DIM)/2*sad_w(PIX_W, 2*BLK_DIM*BLK_DIM)-1:0] sad_8x4,
    output logic [(MB_DIM/BLK_DIM)*(MB_DIM/BLK_DIM)/2*sad_w(PIX_W, 2*BLK_DIM*BLK_DIM)-1:0] sad_4x8,
    output logic [4*sad_w(PIX_W, MB_DIM*MB_DIM/4)-1:0] sad_8x8,
    output logic [2*sad_w(PIX_W, MB_DIM*MB_DIM/2)-1:0] sad_16x8,
    output logic [2*sad_w(PIX_W, MB_DIM*MB_DIM/2)-1:0] sad_8x16,
    output logic [sad_w(PIX_W, MB_DIM*MB_DIM)-1:0]     sad_16x16
);

    localparam int NB   = MB_DIM / BLK_DIM;
    localparam int NBLK = NB * NB;
    localparam int BPIX = BLK_DIM * BLK_DIM;
    localparam int NPIX = MB_DIM * MB_DIM;
    localparam int W4   = sad_w(PIX_W, BPIX);

    logic [NPIX*PIX_W-1:0]  ad_q;
    logic [NBLK*W4-1:0]     s4;
    logic [SAD_LATENCY-1:0] vld_pipe;

    vbs_absdiff_array #(
        .PIX_W (PIX_W),
        .NPIX  (NPIX)
    ) u_absdiff (
        .clk     (clk),
        .cur_pix (cur_pix),
        .ref_pix (ref_pix),
        .ad_q    (ad_q)
    );

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        logic [BPIX*PIX_W-1:0] ad_blk;

        for (genvar y = 0; y < BLK_DIM; y++) begin : g_row
            for (genvar x = 0; x < BLK_DIM; x++) begin : g_col
                assign ad_blk[(y*BLK_DIM + x)*PIX_W +: PIX_W] =
                    ad_q[(((b/NB)*BLK_DIM + y)*MB_DIM + (b%NB)*BLK_DIM + x)*PIX_W +: PIX_W];
            end
        end

        vbs_blk_sad #(
            .PIX_W   (PIX_W),
            .BLK_DIM (BLK_DIM)
        ) u_blk (
            .clk    (clk),
            .ad_blk (ad_blk),
            .sad_q  (s4[b*W4 +: W4])
        );
    end

    vbs_part_merge #(
        .PIX_W   (PIX_W),
        .MB_DIM  (MB_DIM),
        .BLK_DIM (BLK_DIM)
    ) u_merge (
        .clk       (clk),
        .s4_in     (s4),
        .sad_4x4   (sad_4x4),
        .sad_8x4   (sad_8x4),
        .sad_4x8   (sad_4x8),
        .sad_8x8   (sad_8x8),
        .sad_16x8  (sad_16x8),
        .sad_8x16  (sad_8x16),
        .sad_16x16 (sad_16x16)
    );

    // Carry the valid flag alongside the data through all stages
    always_ff @(posedge clk) begin
        if (!rst_n) vld_pipe <= '0;
        else        vld_pipe <= {vld_pipe[SAD_LATENCY-2:0], in_valid};
    end

    assign out_valid = vld_pipe[SAD_LATENCY-1];

endmodule

// File: rtl/vbs_sad_engine_chk.sv
// Module: assertion checker for vbs_sad_engine, attached by bind below.
// Checks the valid latency, the quiet period after reset, the range of the
// 4x4 results and the consistency between partition groups.
module vbs_sad_engine_chk import vbs_sad_pkg::*; #(
    parameter int PIX_W   = 8,
    parameter int MB_DIM  = 16,
    parameter int BLK_DIM = 4
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic out_valid,
    input logic [(MB_DIM/BLK_DIM)*(MB_DIM/BLK_DIM)*sad_w(PIX_W, BLK_DIM*BLK_DIM)-1:0]   sad_4x4,
    input logic [(MB_DIM/BLK_DIM)*(MB_DIM/BLK_DIM)/2*sad_w(PIX_W, 2*BLK_DIM*BLK_DIM)-1:0] sad_8x4,
    input logic [(MB_DIM/BLK_DIM)*(MB_DIM/BLK_DIM)/2*sad_w(PIX_W, 2*BLK_DIM*BLK_DIM)-1:0] sad_4x8,
    input logic [4*sad_w(PIX_W, MB_DIM*MB_DIM/4)-1:0] sad_8x8,
    input logic [2*sad_w(PIX_W, MB_DIM*MB_DIM/2)-1:0] sad_16x8,
    input logic [2*sad_w(PIX_W, MB_DIM*MB_DIM/2)-1:0] sad_8x16,
    input logic [sad_w(PIX_W, MB_DIM*MB_DIM)-1:0]     sad_16x16
);

    localparam int NB   = MB_DIM / BLK_DIM;
    localparam int BPIX = BLK_DIM * BLK_DIM;
    localparam int NPIX = MB_DIM * MB_DIM;
    localparam int W4   = sad_w(PIX_W, BPIX);
    localparam int W84  = sad_w(PIX_W, 2*BPIX);
    localparam int W88  = sad_w(PIX_W, NPIX/4);
    localparam int WH   = sad_w(PIX_W, NPIX/2);
    localparam int WT   = sad_w(PIX_W, NPIX);
    localparam int MAX4 = BPIX * ((1 << PIX_W) - 1);

    logic [2:0] since_rst;

    // Count cycles since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R7: out_valid follows in_valid by exactly SAD_LATENCY cycles
    a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'(SAD_LATENCY)) |-> (out_valid == $past(in_valid, SAD_LATENCY)));

    // R9: nothing is flagged before a post-reset beat can reach the output
    a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 3'(SAD_LATENCY)) |-> !out_valid);

    for (genvar k = 0; k < NB*NB; k++) begin : g_r2
        // R2: a 4x4 SAD never exceeds its full-scale value
        a_r2_range_4x4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (32'(sad_4x4[k*W4 +: W4]) <= MAX4));
    end

    for (genvar j = 0; j < NB*NB/2; j++) begin : g_r3
        // R3: each wide and tall pair equals its two 4x4 outputs
        a_r3_pair_sums: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |->
            (sad_8x4[j*W84 +: W84] ==
                W84'(sad_4x4[((j/2)*NB + 2*(j%2))*W4 +: W4]) +
                W84'(sad_4x4[((j/2)*NB + 2*(j%2) + 1)*W4 +: W4])) &&
            (sad_4x8[j*W84 +: W84] ==
                W84'(sad_4x4[((2*(j/NB))*NB + (j%NB))*W4 +: W4]) +
                W84'(sad_4x4[((2*(j/NB)+1)*NB + (j%NB))*W4 +: W4])));
    end

    for (genvar q = 0; q < 4; q++) begin : g_r4
        // R4: each 8x8 equals the two 8x4 outputs stacked inside it
        a_r4_quad_sum: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |->
            (sad_8x8[q*W88 +: W88] ==
                W88'(sad_8x4[((2*(q/2))*2 + (q%2))*W84 +: W84]) +
                W88'(sad_8x4[((2*(q/2)+1)*2 + (q%2))*W84 +: W84])));
    end

    // R5: each half equals the two 8x8 outputs it spans
    a_r5_half_sums: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |->
        (sad_16x8[0 +: WH]  == WH'(sad_8x8[0 +: W88]) + WH'(sad_8x8[W88 +: W88])) &&
        (sad_16x8[WH +: WH] == WH'(sad_8x8[2*W88 +: W88]) + WH'(sad_8x8[3*W88 +: W88])) &&
        (sad_8x16[0 +: WH]  == WH'(sad_8x8[0 +: W88]) + WH'(sad_8x8[2*W88 +: W88])) &&
        (sad_8x16[WH +: WH] == WH'(sad_8x8[W88 +: W88]) + WH'(sad_8x8[3*W88 +: W88])));

    // R6: the whole-block SAD agrees with both split directions
    a_r6_total_sum: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |->
        (sad_16x16 == WT'(sad_16x8[0 +: WH]) + WT'(sad_16x8[WH +: WH])) &&
        (sad_16x16 == WT'(sad_8x16[0 +: WH]) + WT'(sad_8x16[WH +: WH])));

endmodule

bind vbs_sad_engine vbs_sad_engine_chk #(
    .PIX_W   (PIX_W),
    .MB_DIM  (MB_DIM),
    .BLK_DIM (BLK_DIM)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .sad_4x4   (sad_4x4),
    .sad_8x4   (sad_8x4),
    .sad_4x8   (sad_4x8),
    .sad_8x8   (sad_8x8),
    .sad_16x8  (sad_16x8),
    .sad_8x16  (sad_8x16),
    .sad_16x16 (sad_16x16)
);

// File: tb/sim_vbs_sad_engine.sv
// Bench for vbs_sad_engine: seeded random and directed pixel patterns,
// expected SADs computed directly from pixel regions.
module sim_vbs_sad_engine;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2047:0] cur_pix = '0;
    logic [2047:0] ref_pix = '0;
    logic          out_valid;
    logic [191:0]  sad_4x4;
    logic [103:0]  sad_8x4;
    logic [103:0]  sad_4x8;
    logic [55:0]   sad_8x8;
    logic [29:0]   sad_16x8;
    logic [29:0]   sad_8x16;
    logic [15:0]   sad_16x16;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] cb [256];
    logic [7:0] rb [256];

    // Expected-value ring, indexed by beat number modulo 8
    logic         hv   [8];
    logic [191:0] h4   [8];
    logic [103:0] h84  [8];
    logic [103:0] h48  [8];
    logic [55:0]  h88  [8];
    logic [29:0]  h168 [8];
    logic [29:0]  h816 [8];
    logic [15:0]  h16  [8];
    int           t;

    vbs_sad_engine u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .cur_pix   (cur_pix),
        .ref_pix   (ref_pix),
        .out_valid (out_valid),
        .sad_4x4   (sad_4x4),
        .sad_8x4   (sad_8x4),
        .sad_4x8   (sad_4x8),
        .sad_8x8   (sad_8x8),
        .sad_16x8  (sad_16x8),
        .sad_8x16  (sad_8x16),
        .sad_16x16 (sad_16x16)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run is a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    function automatic int region_sad(input int x0, input int y0, input int w, input int h);
        int s = 0;
        for (int y = y0; y < y0 + h; y++)
            for (int x = x0; x < x0 + w; x++) begin
                int d = int'(cb[y*16+x]) - int'(rb[y*16+x]);
                s += (d < 0) ? -d : d;
            end
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input logic [191:0] act,
                         input logic [191:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Fill pixel arrays for a pattern: 0 random, 1 cur full/ref zero,
    // 2 cur zero/ref full, 3 equal, 4 per-block level, 5 one pixel differs,
    // 6 small signed offsets
    task automatic fill(input int mode);
        int sel;
        sel = $urandom_range(0, 255);
        for (int p = 0; p < 256; p++) begin
            case (mode)
                1: begin cb[p] = 8'hFF; rb[p] = 8'h00; end
                2: begin cb[p] = 8'h00; rb[p] = 8'hFF; end
                3: begin cb[p] = 8'($urandom); rb[p] = cb[p]; end
                4: begin cb[p] = 8'(((p/64)*4 + (p%16)/4) * 13); rb[p] = 8'h00; end
                5: begin cb[p] = 8'($urandom); rb[p] = cb[p]; end
                6: begin rb[p] = 8'($urandom_range(20, 235));
                          cb[p] = 8'(int'(rb[p]) + $urandom_range(0, 40) - 20); end
                default: begin cb[p] = 8'($urandom); rb[p] = 8'($urandom); end
            endcase
        end
        if (mode == 5) rb[sel] = cb[sel] ^ 8'($urandom_range(1, 255));
        for (int p = 0; p < 256; p++) begin
            cur_pix[p*8 +: 8] = cb[p];
            ref_pix[p*8 +: 8] = rb[p];
        end
    endtask

    task automatic record(input logic v);
        int i = t % 8;
        hv[i] = v;
        for (int k = 0; k < 16; k++) h4[i][k*12 +: 12] = 12'(region_sad((k%4)*4, (k/4)*4, 4, 4));
        for (int j = 0; j < 8; j++) begin
            h84[i][j*13 +: 13] = 13'(region_sad((j%2)*8, (j/2)*4, 8, 4));
            h48[i][j*13 +: 13] = 13'(region_sad((j%4)*4, (j/4)*8, 4, 8));
        end
        for (int q = 0; q < 4; q++) h88[i][q*14 +: 14] = 14'(region_sad((q%2)*8, (q/2)*8, 8, 8));
        for (int k = 0; k < 2; k++) begin
            h168[i][k*15 +: 15] = 15'(region_sad(0, k*8, 16, 8));
            h816[i][k*15 +: 15] = 15'(region_sad(k*8, 0, 8, 16));
        end
        h16[i] = 16'(region_sad(0, 0, 16, 16));
    endtask

    // One cycle: check the beat issued LAT cycles ago, then drive a new one
    task automatic step(input logic v, input int mode);
        @(negedge clk);
        if (t >= LAT) begin
            int i = (t - LAT) % 8;
            check(out_valid == hv[i], "R7/R10 out_valid", 192'(out_valid), 192'(hv[i]));
            if (hv[i] && out_valid) begin
                check(sad_4x4 == h4[i], "R1/R2 sad_4x4", sad_4x4, h4[i]);
                check(sad_8x4 == h84[i] && sad_4x8 == h48[i], "R3 pairs",
                      {sad_8x4, sad_4x8}, {h84[i], h48[i]});
                check(sad_8x8 == h88[i], "R4 sad_8x8", 192'(sad_8x8), 192'(h88[i]));
                check(sad_16x8 == h168[i] && sad_8x16 == h816[i], "R5 halves",
                      {sad_16x8, sad_8x16}, {h168[i], h816[i]});
                check(sad_16x16 == h16[i], "R6 sad_16x16", 192'(sad_16x16), 192'(h16[i]));
            end
        end else begin
            check(!out_valid, "R9 quiet after reset", 192'(out_valid), 192'(0));
        end
        fill(mode);
        in_valid = v;
        record(v);
        t++;
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b1;
        fill(0);
        repeat (cycles) begin
            @(negedge clk);
            check(!out_valid, "R9 low during reset", 192'(out_valid), 192'(0));
        end
        for (int i = 0; i < 8; i++) hv[i] = 1'b0;
        t = 0;
        rst_n = 1'b1;
        in_valid = 1'b0;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h0005AD17);
        t = 0;
        for (int i = 0; i < 8; i++) hv[i] = 1'b0;

        // R9: reset with in_valid high
        do_reset(6);

        // R8: back-to-back directed corner cases, R2 and R6 at full scale
        step(1'b1, 1);
        step(1'b1, 2);
        step(1'b1, 3);
        step(1'b1, 4);
        step(1'b1, 5);
        step(1'b1, 6);
        // R1: random beats, every cycle
        for (int n = 0; n < 200; n++) step(1'b1, n % 7);
        // R10: idle gaps carrying data
        for (int n = 0; n < 200; n++) step(1'(($urandom % 3) != 0), n % 7);
        // R9: reset while beats are in flight drops them
        for (int n = 0; n < 3; n++) step(1'b1, 0);
        do_reset(2);
        for (int n = 0; n < 40; n++) step(1'(n % 2), 0);
        for (int n = 0; n < LAT + 1; n++) step(1'b0, 0);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule